// File: doc/BRIEF.md
# Serial Audio Transmitter with Source Select

This block sends one stereo pair of 24-bit two's-complement samples per frame on a single serial data line. The bit clock and the word clock come from outside. Both are brought into the system clock domain, and their edges are found there. A two-bit format code chooses how the data lines up against the word clock. Codes 0, 1 and 2 give 24-bit left-justified framing with the left channel while the word clock is high. Code 3 gives I2S framing with the left channel while the word clock is low, and the MSB delayed by one bit clock.

A source-select input chooses which samples are sent. When it is low, the block sends the internally produced pair, for example converter output. When it is high, it sends the pair recovered from an auxiliary serial input, which leaves in the output format whatever format it arrived in. A time-division-multiplexed mode input overrides the selection, so that mode always sends the internal pair. The format, the source choice and both samples are captured together when a frame starts, so inputs that change later in the frame do not disturb it.

Top module: `stx_serial_tx`

## Requirements
- R1: After reset, and until the first frame start is seen, the serial output stays low.
- R2: With format codes 00, 01 and 10, the 24 bits of a channel leave MSB first, as two's complement. The MSB is driven on the first falling bit-clock edge after the rising edge at which the new word-clock level is sampled.
- R3: With format code 11, every data bit of a channel is driven one bit clock later than under R2.
- R4: The left sample is sent in the half where the word clock is high for codes 00, 01 and 10, and low for code 11. A frame starts when the word clock changes to the left-channel level.
- R5: After the 24th data bit of a channel, the output is low for every remaining bit clock of that half.
- R6: With source select low the internal sample pair is sent. With source select high, and the multiplexed mode input low, the auxiliary pair is sent.
- R7: While the multiplexed mode input is high at frame start, the internal pair is sent whatever the source select is.
- R8: Samples, source select and the multiplexed mode input are latched at frame start. Changes to them during a frame have no effect on that frame's output.
- R9: The serial output changes only in the system clock cycle that follows a detected falling edge of the bit clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than four times the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | External bit clock |
| wclk_i | input | 1 | External word clock |
| fmt_i | input | 2 | Format code: 00/01/10 left-justified, 11 I2S |
| src_sel_i | input | 1 | 0 sends internal samples, 1 sends auxiliary samples |
| tdm_en_i | input | 1 | Multiplexed mode; forces the internal source |
| core_l_i | input | 24 | Internal left sample |
| core_r_i | input | 24 | Internal right sample |
| aux_l_i | input | 24 | Auxiliary left sample |
| aux_r_i | input | 24 | Auxiliary right sample |
| sdo_o | output | 1 | Serial data output |

## Verification
A bit counter that goes wrong shows up as a whole channel shifted by one or more bit positions, or as data leaking into the low tail. The bench compares every bit clock, so this is caught within the first bits of the next channel. A wrong channel flag or a wrong frame-start decision swaps the left and right words, and the first half of the affected frame exposes it. A latch that fails to hold shows up as the mid-frame values of the sample and select inputs appearing in the right channel of the same frame.

// File: rtl/stx_pkg.sv
package stx_pkg;

    typedef enum logic [1:0] {
        FMT_LJ_A = 2'b00,
        FMT_LJ_B = 2'b01,
        FMT_LJ_C = 2'b10,
        FMT_I2S  = 2'b11
    } fmt_e;

    function automatic logic fmt_is_i2s(input logic [1:0] code);
        return code == FMT_I2S;
    endfunction

    // word-clock level that marks the left half
    function automatic logic left_level(input logic [1:0] code);
        return !fmt_is_i2s(code);
    endfunction

endpackage

// File: rtl/stx_sync.sv
module stx_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    typedef logic [STAGES-1:0][WIDTH-1:0] chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/stx_frame.sv
module stx_frame
    import stx_pkg::*;
#(
    parameter int WIDTH = 24,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_s_i,
    input  logic             wclk_s_i,
    input  logic [1:0]       fmt_i,
    input  logic             src_sel_i,
    input  logic             tdm_en_i,
    input  logic [WIDTH-1:0] core_l_i,
    input  logic [WIDTH-1:0] core_r_i,
    input  logic [WIDTH-1:0] aux_l_i,
    input  logic [WIDTH-1:0] aux_r_i,
    output logic             fall_o,
    output logic             frame_start_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             left_o,
    output logic             valid_o,
    output logic             i2s_o,
    output logic [WIDTH-1:0] word_l_o,
    output logic [WIDTH-1:0] word_r_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             bclk_prev;
        logic             wclk_last;
        logic [CNT_W-1:0] cnt;
        logic             left;
        logic             valid;
        logic [1:0]       fmt;
        logic [WIDTH-1:0] word_l;
        logic [WIDTH-1:0] word_r;
    } state_t;

    state_t st_d, st_q;
    logic   rise, fall, wclk_edge, start;
    logic   use_aux;

    always_comb begin
        st_d      = st_q;
        rise      = bclk_s_i && !st_q.bclk_prev;
        fall      = !bclk_s_i && st_q.bclk_prev;
        wclk_edge = rise && (wclk_s_i != st_q.wclk_last);
        start     = wclk_edge && (wclk_s_i == left_level(fmt_i));
        use_aux   = src_sel_i && !tdm_en_i;

        st_d.bclk_prev = bclk_s_i;

        if (rise) begin
            st_d.wclk_last = wclk_s_i;
            if (wclk_edge) begin
                st_d.cnt  = '0;
                st_d.left = start ? 1'b1
                                  : (wclk_s_i == left_level(st_q.fmt));
            end else if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        if (start) begin
            st_d.valid  = 1'b1;
            st_d.fmt    = fmt_i;
            st_d.word_l = use_aux ? aux_l_i : core_l_i;
            st_d.word_r = use_aux ? aux_r_i : core_r_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fall_o        = fall;
    assign frame_start_o = start;
    assign cnt_o         = st_q.cnt;
    assign left_o        = st_q.left;
    assign valid_o       = st_q.valid;
    assign i2s_o         = fmt_is_i2s(st_q.fmt);
    assign word_l_o      = st_q.word_l;
    assign word_r_o      = st_q.word_r;

    // R8: latched samples only move at a frame start
    a_r8_hold_words: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(st_q.word_l) && $stable(st_q.word_r)));

    // R2: a sampled word-clock change restarts the bit position
    a_r2_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
        wclk_edge |=> (st_q.cnt == '0));
endmodule

// File: rtl/stx_shift.sv
module stx_shift #(
    parameter int WIDTH = 24,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             left_i,
    input  logic             valid_i,
    input  logic             i2s_i,
    input  logic [WIDTH-1:0] word_l_i,
    input  logic [WIDTH-1:0] word_r_i,
    output logic             sdo_o
);
    localparam int IDX_W = $clog2(WIDTH);
    localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(WIDTH);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WIDTH - 1);

    logic             sdo_d, sdo_q;
    logic [CNT_W-1:0] pos;
    logic [IDX_W-1:0] idx;
    logic [WIDTH-1:0] word;
    logic             in_range;

    always_comb begin
        pos      = cnt_i - {{(CNT_W-1){1'b0}}, i2s_i};
        in_range = valid_i && (cnt_i >= {{(CNT_W-1){1'b0}}, i2s_i}) && (pos < LIMIT);
        idx      = TOP_IDX - pos[IDX_W-1:0];
        word     = left_i ? word_l_i : word_r_i;
        sdo_d    = sdo_q;
        if (fall_i) begin
            sdo_d = in_range ? word[idx] : 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdo_q <= 1'b0;
        end else begin
            sdo_q <= sdo_d;
        end
    end

    assign sdo_o = sdo_q;

    // R9: output moves only right after a bit-clock fall
    a_r9_move_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_q != $past(sdo_q)) |-> $past(fall_i));
endmodule

// File: rtl/stx_serial_tx.sv
module stx_serial_tx #(
    parameter int WIDTH       = 24,
    parameter int CNT_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_i,
    input  logic             wclk_i,
    input  logic [1:0]       fmt_i,
    input  logic             src_sel_i,
    input  logic             tdm_en_i,
    input  logic [WIDTH-1:0] core_l_i,
    input  logic [WIDTH-1:0] core_r_i,
    input  logic [WIDTH-1:0] aux_l_i,
    input  logic [WIDTH-1:0] aux_r_i,
    output logic             sdo_o
);
    logic [1:0]       clk_s;
    logic             fall, frame_start, left, valid, i2s;
    logic [CNT_W-1:0] cnt;
    logic [WIDTH-1:0] word_l, word_r;

    stx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({wclk_i, bclk_i}),
        .q_o   (clk_s)
    );

    stx_frame #(.WIDTH(WIDTH), .CNT_W(CNT_W)) frame_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bclk_s_i      (clk_s[0]),
        .wclk_s_i      (clk_s[1]),
        .fmt_i         (fmt_i),
        .src_sel_i     (src_sel_i),
        .tdm_en_i      (tdm_en_i),
        .core_l_i      (core_l_i),
        .core_r_i      (core_r_i),
        .aux_l_i       (aux_l_i),
        .aux_r_i       (aux_r_i),
        .fall_o        (fall),
        .frame_start_o (frame_start),
        .cnt_o         (cnt),
        .left_o        (left),
        .valid_o       (valid),
        .i2s_o         (i2s),
        .word_l_o      (word_l),
        .word_r_o      (word_r)
    );

    stx_shift #(.WIDTH(WIDTH), .CNT_W(CNT_W)) shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fall_i   (fall),
        .cnt_i    (cnt),
        .left_i   (left),
        .valid_i  (valid),
        .i2s_i    (i2s),
        .word_l_i (word_l),
        .word_r_i (word_r),
        .sdo_o    (sdo_o)
    );

    // R1: nothing is sent before the first frame start
    a_r1_quiet_before_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> !sdo_o);

    // R7: multiplexed mode captures the internal left sample
    a_r7_tdm_core_left: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && tdm_en_i) |=> (word_l == $past(core_l_i)));

    a_r7_tdm_core_right: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && tdm_en_i) |=> (word_r == $past(core_r_i)));
endmodule

// File: tb/stx_serial_tx_tb_top.sv
module stx_serial_tx_tb_top;
    localparam int HALF  = 8;
    localparam int SLOTS = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0;
    logic        wclk = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic        src_sel = 1'b0;
    logic        tdm_en = 1'b0;
    logic [23:0] core_l = '0, core_r = '0, aux_l = '0, aux_r = '0;
    logic        sdo;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    bit  cur_lvl  = 1'b0;

    always #2 clk = ~clk;

    stx_serial_tx dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_i    (bclk),
        .wclk_i    (wclk),
        .fmt_i     (fmt),
        .src_sel_i (src_sel),
        .tdm_en_i  (tdm_en),
        .core_l_i  (core_l),
        .core_r_i  (core_r),
        .aux_l_i   (aux_l),
        .aux_r_i   (aux_r),
        .sdo_o     (sdo)
    );

    function automatic logic exp_bit(input logic [23:0] w, input int m, input bit i2s);
        int p;
        if (m < 1) return 1'b0;
        p = m - 1 - int'(i2s);
        if (p < 0 || p >= 24) return 1'b0;
        return w[23-p];
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: sdo=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic run_half(input bit lvl, input logic [23:0] w, input bit i2s,
                            input bit chk, input string tag, input bit mut);
        for (int m = 0; m < SLOTS; m++) begin
            bclk = 1'b0;
            wclk = lvl;
            repeat (HALF) @(negedge clk);
            if (chk) begin
                int p;
                p = m - 1 - int'(i2s);
                check(sdo, exp_bit(w, m, i2s),
                      (p >= 24) ? "R5 tail" : tag);
            end
            if (mut && m == 5) begin
                core_l  = 24'($urandom);
                core_r  = 24'($urandom);
                aux_l   = 24'($urandom);
                aux_r   = 24'($urandom);
                src_sel = ~src_sel;
                tdm_en  = ~tdm_en;
            end
            bclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic run_frame(input logic [1:0] f, input logic [23:0] cl, input logic [23:0] cr,
                             input logic [23:0] al, input logic [23:0] ar,
                             input bit src, input bit tdm, input bit mut);
        bit i2s, llvl, aux;
        logic [23:0] wl, wr;
        string tag;
        i2s  = (f == 2'b11);
        llvl = !i2s;
        fmt  = f;
        if (cur_lvl != !llvl) begin
            run_half(!llvl, '0, i2s, 1'b0, "", 1'b0);
        end
        core_l = cl; core_r = cr; aux_l = al; aux_r = ar;
        src_sel = src; tdm_en = tdm;
        aux = src && !tdm;
        wl  = aux ? al : cl;
        wr  = aux ? ar : cr;
        tag = $sformatf("%s R4 %s%s", i2s ? "R3" : "R2", tdm ? "R7" : "R6", mut ? " R8" : "");
        run_half(llvl, wl, i2s, 1'b1, {tag, " left"}, mut);
        run_half(!llvl, wr, i2s, 1'b1, {tag, " right"}, 1'b0);
        cur_lvl = !llvl;
    endtask

    initial begin
        void'($urandom(32'h5A17));
        repeat (5) @(negedge clk);
        check(sdo, 1'b0, "R1 reset");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // idle traffic before any frame start: R1
        core_l = 24'hFFFFFF; core_r = 24'hFFFFFF;
        run_half(1'b0, '0, 1'b0, 1'b1, "R1 idle", 1'b0);

        run_frame(2'b00, 24'h800001, 24'h7FFFFE, 24'h0, 24'h0, 1'b0, 1'b0, 1'b0);
        run_frame(2'b01, 24'h123456, 24'hABCDEF, 24'hC0FFEE, 24'h0F0F0F, 1'b1, 1'b0, 1'b0);
        run_frame(2'b10, 24'hFFFFFF, 24'h000001, 24'h555555, 24'hAAAAAA, 1'b0, 1'b0, 1'b1);
        run_frame(2'b11, 24'h800000, 24'h7FFFFF, 24'h111111, 24'h222222, 1'b0, 1'b0, 1'b0);
        run_frame(2'b11, 24'hA5A5A5, 24'h5A5A5A, 24'hFFFFFF, 24'hFFFFFF, 1'b1, 1'b1, 1'b0);
        run_frame(2'b11, 24'h13579B, 24'h2468AC, 24'h987654, 24'h0000FF, 1'b1, 1'b0, 1'b1);
        run_frame(2'b00, 24'h000000, 24'hFFFFFF, 24'h800000, 24'h800000, 1'b1, 1'b1, 1'b0);

        for (int k = 0; k < 14; k++) begin
            run_frame(2'($urandom), 24'($urandom), 24'($urandom), 24'($urandom),
                      24'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule